// File: doc/BRIEF.md
# Handshake-Checked Set/Reset Latch

This block is a clocked, cycle-accurate model of a set/reset latch whose requests follow a four-phase handshake. A request on `s` drives the latch to the set state (`q`=1, `nq`=0). A request on `r` drives it to the reset state (`q`=0, `nq`=1). The environment holds a request high until it sees the outputs settle, and only then withdraws it. Each change of state passes through one cycle with both outputs low, so the two outputs are never high together.

An optional enable input gates the requests. While the enable is inactive, requests are ignored and the outputs hold their values. A change that has already started still completes.

The block also watches its environment and raises three sticky error flags:
- requesting set and reset in the same cycle;
- releasing `s` before the latch has reached the set state;
- releasing `r` before it has reached the reset state.

A synchronous active-low reset returns everything to the initial state. Inputs are assumed to be synchronous to `clk`.

Top module: `hs_sr_latch`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the block enters `q`=0, `nq`=1 with all three error flags at 0.
- R2: `q` and `nq` are never 1 in the same cycle.
- R3: In the reset state, an active request (`s`=1, `r`=0, enable active) sampled at an edge gives `q`=0, `nq`=0 after that edge, and `q`=1, `nq`=0 after the following edge.
- R4: In the set state, an active request (`r`=1, `s`=0, enable active) gives `q`=0, `nq`=0 after that edge, and `q`=0, `nq`=1 after the following edge.
- R5: With `HAS_ENABLE`=1, the enable is active when `en` equals `EN_ACTIVE_HIGH` (default: active when 1). While the enable is inactive, requests cause no change and a settled output pair holds its value.
- R6: `s`=1 together with `r`=1 at an edge sets `err_contra` and is ignored: a settled output pair keeps its value.
- R7: If `s` is 1 at one edge and 0 at the next while `q` is 0 at that next edge, `err_set_early` becomes 1.
- R8: If `r` is 1 at one edge and 0 at the next while `nq` is 0 at that next edge, `err_rst_early` becomes 1.
- R9: A set request while `q`=1, or a reset request while `nq`=1, causes no output change.
- R10: Once set, each error flag stays 1 until reset.
- R11: The state with both outputs at 0 lasts exactly one cycle, and is always followed by exactly one output at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s | input | 1 | Set request |
| r | input | 1 | Reset request |
| en | input | 1 | Request enable; polarity from `EN_ACTIVE_HIGH`; ignored when `HAS_ENABLE`=0 |
| q | output | 1 | True output |
| nq | output | 1 | Complementary output |
| err_contra | output | 1 | Sticky flag: set and reset requested together |
| err_set_early | output | 1 | Sticky flag: set request withdrawn before `q` rose |
| err_rst_early | output | 1 | Sticky flag: reset request withdrawn before `nq` rose |

## Verification
Properties check the following on every cycle:
- mutual exclusion of the outputs;
- the single-cycle gap and its two-step order;
- that a redundant request, a contradictory request, or a disabled request leaves a settled pair untouched;
- that each flag rises after its violation and then stays set.

Only the bench scenarios can show that a whole handshake ends in the right final state across long request sequences. They also show the exact cycle at which each flag first appears, how the enable interacts with a request that is held across it, and that a reset in the middle of a run clears every flag. These scenarios mix a constrained-random, well-behaved environment with injected protocol violations.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   // Latch control state; the two gap states hold both outputs low
   typedef enum logic [1:0] {
      LS_RESET    = 2'd0,
      LS_TO_SET   = 2'd1,
      LS_SET      = 2'd2,
      LS_TO_RESET = 2'd3
   } lstate_e;

   typedef struct packed {
      logic contra;
      logic set_early;
      logic rst_early;
   } herr_t;

   localparam int unsigned HERR_W = $bits(herr_t);

endpackage

// File: rtl/hsl_req_gate.sv
module hsl_req_gate #(
   parameter int HAS_ENABLE     = 1,
   parameter int EN_ACTIVE_HIGH = 1
) (
   input  logic s,
   input  logic r,
   input  logic en,
   output logic set_req,
   output logic rst_req,
   output logic both_req
);

   logic en_act;

   generate
      if (HAS_ENABLE != 0) begin : g_enable
         if (EN_ACTIVE_HIGH != 0) begin : g_high
            assign en_act = en;
         end else begin : g_low
            assign en_act = ~en;
         end
      end else begin : g_no_enable
         logic unused_en;
         assign unused_en = en;
         assign en_act    = 1'b1;
      end
   endgenerate

   assign both_req = s & r;
   assign set_req  = en_act & s & ~r;
   assign rst_req  = en_act & r & ~s;

endmodule

// File: rtl/hsl_sequencer.sv
module hsl_sequencer
   import hsl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic rst_req,
   output logic q,
   output logic nq
);

   lstate_e state, state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         LS_RESET:    if (set_req) state_nx = LS_TO_SET;
         LS_TO_SET:   state_nx = LS_SET;
         LS_SET:      if (rst_req) state_nx = LS_TO_RESET;
         LS_TO_RESET: state_nx = LS_RESET;
         default:     state_nx = LS_RESET;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LS_RESET;
         q     <= 1'b0;
         nq    <= 1'b1;
      end else begin
         state <= state_nx;
         q     <= (state_nx == LS_SET);
         nq    <= (state_nx == LS_RESET);
      end
   end

   a_r2_mutex: assert property (@(posedge clk) disable iff (!rst_n)
      !(q && nq));

   a_r3_set_first: assert property (@(posedge clk) disable iff (!rst_n)
      (nq && set_req) |=> (!q && !nq));

   a_r3_set_second: assert property (@(posedge clk) disable iff (!rst_n)
      (nq && set_req) |=> ##1 (q && !nq));

   a_r4_reset_first: assert property (@(posedge clk) disable iff (!rst_n)
      (q && rst_req) |=> (!q && !nq));

   a_r4_reset_second: assert property (@(posedge clk) disable iff (!rst_n)
      (q && rst_req) |=> ##1 (!q && nq));

   a_r9_redundant_set: assert property (@(posedge clk) disable iff (!rst_n)
      (q && set_req) |=> (q && !nq));

   a_r9_redundant_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (nq && rst_req) |=> (nq && !q));

   a_r11_gap_once: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !nq) |=> (q != nq));

endmodule

// File: rtl/hsl_monitor.sv
module hsl_monitor
   import hsl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  s,
   input  logic  r,
   input  logic  q,
   input  logic  nq,
   output herr_t err
);

   logic s_d, r_d;
   herr_t hit;

   always_comb begin
      hit.contra    = s & r;
      hit.set_early = s_d & ~s & ~q;
      hit.rst_early = r_d & ~r & ~nq;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_d <= 1'b0;
         r_d <= 1'b0;
         err <= '0;
      end else begin
         s_d <= s;
         r_d <= r;
         err <= err | hit;
      end
   end

   a_r6_contra_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (s && r) |=> err.contra);

   a_r7_set_early: assert property (@(posedge clk) disable iff (!rst_n)
      (s && !q) ##1 (!s && !q) |=> err.set_early);

   a_r8_rst_early: assert property (@(posedge clk) disable iff (!rst_n)
      (r && !nq) ##1 (!r && !nq) |=> err.rst_early);

   a_r10_sticky_contra: assert property (@(posedge clk) disable iff (!rst_n)
      err.contra |=> err.contra);

   a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      err.set_early |=> err.set_early);

   a_r10_sticky_rst: assert property (@(posedge clk) disable iff (!rst_n)
      err.rst_early |=> err.rst_early);

endmodule

// File: rtl/hs_sr_latch.sv
module hs_sr_latch
   import hsl_pkg::*;
#(
   parameter int HAS_ENABLE     = 1,
   parameter int EN_ACTIVE_HIGH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic s,
   input  logic r,
   input  logic en,
   output logic q,
   output logic nq,
   output logic err_contra,
   output logic err_set_early,
   output logic err_rst_early
);

   generate
      if (HAS_ENABLE != 0 && HAS_ENABLE != 1) begin : g_chk_has_en
         $error("HAS_ENABLE must be 0 or 1");
      end
      if (EN_ACTIVE_HIGH != 0 && EN_ACTIVE_HIGH != 1) begin : g_chk_pol
         $error("EN_ACTIVE_HIGH must be 0 or 1");
      end
   endgenerate

   localparam logic EN_IDLE_LEVEL = (EN_ACTIVE_HIGH != 0) ? 1'b0 : 1'b1;

   logic  set_req, rst_req, both_req;
   herr_t err;

   hsl_req_gate #(
      .HAS_ENABLE     (HAS_ENABLE),
      .EN_ACTIVE_HIGH (EN_ACTIVE_HIGH)
   ) u_gate (
      .s        (s),
      .r        (r),
      .en       (en),
      .set_req  (set_req),
      .rst_req  (rst_req),
      .both_req (both_req)
   );

   hsl_sequencer u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .rst_req (rst_req),
      .q       (q),
      .nq      (nq)
   );

   hsl_monitor u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .s     (s),
      .r     (r),
      .q     (q),
      .nq    (nq),
      .err   (err)
   );

   assign err_contra    = err.contra;
   assign err_set_early = err.set_early;
   assign err_rst_early = err.rst_early;

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (!q && nq && !err_contra && !err_set_early && !err_rst_early));

   a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((HAS_ENABLE != 0) && (en == EN_IDLE_LEVEL) && (q != nq)) |=> $stable({q, nq}));

   a_r6_contra_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (both_req && (q != nq)) |=> $stable({q, nq}));

endmodule

// File: tb/sim_hs_sr_latch.sv
`timescale 1ns/1ps
module sim_hs_sr_latch;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s = 1'b0, r = 1'b0, en = 1'b1;
   logic q, nq, err_contra, err_set_early, err_rst_early;

   always #2.5 clk = ~clk;

   hs_sr_latch #(.HAS_ENABLE(1), .EN_ACTIVE_HIGH(1)) u0 (
      .clk(clk), .rst_n(rst_n), .s(s), .r(r), .en(en),
      .q(q), .nq(nq), .err_contra(err_contra),
      .err_set_early(err_set_early), .err_rst_early(err_rst_early)
   );

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // expected state
   bit mq, mnq, mc, ms, mr, sp, rp;
   int mpend;

   task automatic model_reset();
      mq = 0; mnq = 1; mc = 0; ms = 0; mr = 0; sp = 0; rp = 0; mpend = 0;
   endtask

   task automatic model_step(bit ns, bit nr, bit nen);
      mc = mc | (ns & nr);
      ms = ms | (sp & !ns & !mq);
      mr = mr | (rp & !nr & !mnq);
      if (mpend == 1) begin mq = 1; mnq = 0; mpend = 0; end
      else if (mpend == 2) begin mq = 0; mnq = 1; mpend = 0; end
      else if (nen && ns && !nr && !mq) begin mq = 0; mnq = 0; mpend = 1; end
      else if (nen && nr && !ns && !mnq) begin mq = 0; mnq = 0; mpend = 2; end
      sp = ns; rp = nr;
   endtask

   task automatic chk(string tag);
      n_vec++;
      if ({q, nq, err_contra, err_set_early, err_rst_early} !== {mq, mnq, mc, ms, mr}) begin
         n_bad++;
         $display("FAIL %s: got q=%0b nq=%0b err=%b%b%b expected q=%0b nq=%0b err=%b%b%b",
                  tag, q, nq, err_contra, err_set_early, err_rst_early,
                  mq, mnq, mc, ms, mr);
      end
      n_vec++;
      if (q === 1'b1 && nq === 1'b1) begin
         n_bad++;
         $display("FAIL R2: got q=1 nq=1 expected not both high");
      end
   endtask

   task automatic step(bit ns, bit nr, bit nen, string tag);
      s = ns; r = nr; en = nen;
      model_step(ns, nr, nen);
      @(negedge clk);
      chk(tag);
   endtask

   task automatic do_reset();
      rst_n = 0; s = 0; r = 0; en = 1;
      @(negedge clk); @(negedge clk);
      model_reset();
      rst_n = 1;
      chk("R1");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int want;
      void'($urandom(32'd2718));
      @(negedge clk);
      do_reset();

      // R3 / R11: set handshake, gap for one cycle
      step(1, 0, 1, "R3");
      step(1, 0, 1, "R11");
      step(0, 0, 1, "R3");
      // R9: redundant set
      step(1, 0, 1, "R9");
      step(1, 0, 1, "R9");
      step(0, 0, 1, "R9");
      // R5: enable inactive ignores reset request
      step(0, 1, 0, "R5");
      step(0, 1, 0, "R5");
      // R4: enable returns, reset completes
      step(0, 1, 1, "R4");
      step(0, 1, 1, "R4");
      step(0, 0, 1, "R4");
      step(0, 1, 1, "R9");
      step(0, 0, 1, "R9");
      // R6: contradictory request held in reset state
      step(1, 1, 1, "R6");
      step(1, 1, 1, "R6");
      step(0, 0, 1, "R7");
      for (int i = 0; i < 4; i++) step(0, 0, 1, "R10");
      do_reset();
      // R7: s withdrawn during the gap
      step(1, 0, 1, "R7");
      step(0, 0, 1, "R7");
      for (int i = 0; i < 3; i++) step(0, 0, 1, "R10");
      do_reset();
      // R8: r withdrawn during the gap
      step(1, 0, 1, "R3");
      step(1, 0, 1, "R3");
      step(0, 0, 1, "R3");
      step(0, 1, 1, "R8");
      step(0, 0, 1, "R8");
      for (int i = 0; i < 3; i++) step(0, 0, 1, "R10");
      // R6: contradiction in set state keeps outputs
      do_reset();
      step(1, 0, 1, "R3");
      step(1, 0, 1, "R3");
      step(1, 1, 1, "R6");
      step(1, 0, 1, "R6");

      // random handshake environment with rare violations
      for (int round = 0; round < 20; round++) begin
         do_reset();
         want = 0;
         for (int k = 0; k < 300; k++) begin
            bit ns, nr, nen;
            nen = ($urandom % 6) != 0;
            if (want == 1 && mq && mpend == 0) want = 0;
            else if (want == 2 && mnq && mpend == 0) want = 0;
            else if (want == 0 && ($urandom % 3) == 0) want = 1 + ($urandom % 2);
            ns = (want == 1);
            nr = (want == 2);
            if (($urandom % 60) == 0) begin
               ns = $urandom % 2;
               nr = $urandom % 2;
               want = 0;
            end
            step(ns, nr, nen, "R3");
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule